// File: doc/BRIEF.md
# Task Monitor Host Register Front End

This block sits between a host processor and the controller of a multi-task timing monitor. The host reaches four 16-bit registers through a 3-bit select, separate read and write strobes and a 16-bit data path. The registers are read-data, write-data, command and status. Each write to the command register raises a one-cycle pulse and a pending flag toward the controller. The controller then decodes the pace, opcode and task fields of the command word.

Every monitored task drives one overrun request line. The block merges these lines into a single interrupt. A priority encoder picks the lowest-numbered requester. When the controller asserts its capture enable, the block stores that task's ID in the status word, next to a too-fast flag that the controller also loads. The host acknowledges the interrupt. The block then drops the line and sends a one-hot acknowledge to the captured task, so that the task's timer can clear its request. A synchronous clear input resets every register.

Top module: `tmon_host_regs`

## Requirements
- R1: With select 000 and read high, `rdata` shows the read-data register. The controller loads that register through `rdl_en`/`rdl_data`.
- R2: With select 001 and write high, `wdata` is loaded into the write-data register at the clock edge. The register is visible on `wreg`.
- R3: With select 010 and write high, `wdata` is loaded into the command register. Its fields appear as task ID = bits 4..0, command code = bits 8..5 and pace = bits 10..9.
- R4: A command write makes `cmd_valid` high for exactly the following cycle and sets `cmd_pend`. `cmd_pend` stays set until `cmd_pend_clr`. If a command write and `cmd_pend_clr` fall in the same cycle, the write wins.
- R5: With select 011 and read high, `rdata` shows the status word: bits 4..0 are the captured task ID, bit 5 is the too-fast flag, and bits 15..6 are zero. The controller loads the flag through `tf_en`/`tf_in`.
- R6: `irq` is set in the cycle after any `ovr_req` line is high.
- R7: Once set, `irq` stays high until `intack` is sampled high, even if every request has dropped. `intack` has priority, so `irq` is low in the following cycle. While `intack` and `irq` are both high, `ack_vec` is one-hot at the captured ID; otherwise it is zero.
- R8: The ID capture loads the index of the lowest-numbered active request (index 0 has the highest priority), and only in cycles where `id_en` is high. Otherwise the ID is held.
- R9: `clr` resets all registers, the interrupt, the pending flag and the command pulse to zero.
- R10: A write with select 000, 011 or 1xx changes no register. A read with any select other than 000 or 011, and any cycle without read, drives `rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear of the whole block |
| sel | input | 3 | Register select |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe |
| wdata | input | DW | Host write data |
| rdata | output | DW | Host read data |
| ovr_req | input | NTASK | Per-task overrun requests |
| intack | input | 1 | Host interrupt acknowledge |
| irq | output | 1 | Interrupt request to host |
| ack_vec | output | NTASK | One-hot acknowledge to the captured task |
| id_en | input | 1 | Controller strobe to capture the encoded ID |
| tf_en | input | 1 | Controller strobe to load the too-fast flag |
| tf_in | input | 1 | Too-fast flag value |
| rdl_en | input | 1 | Controller strobe to load the read-data register |
| rdl_data | input | DW | Value for the read-data register |
| wreg | output | DW | Write-data register contents |
| cmd_task | output | 5 | Command task ID field |
| cmd_code | output | 4 | Command opcode field |
| cmd_pace | output | 2 | Command pace field |
| cmd_valid | output | 1 | One-cycle pulse after a command write |
| cmd_pend | output | 1 | Command pending flag |
| cmd_pend_clr | input | 1 | Controller clear of the pending flag |

## Verification
The bench builds the block with its defaults, NTASK = 32 and DW = 16, so the extreme task IDs 0 and 31 and the full 5-bit ID field can all be reached. With random request arrivals, several requests are often pending at once. This exercises the encoder's choice, the re-raising of the interrupt after an acknowledge while other requests remain, and the retention of the captured ID against later arrivals. Random selects combined with both strobes reach the ignored write selects and the zero-returning reads.

// File: rtl/tmon_host_regs.sv
`timescale 1ns/1ps
module tmon_host_regs #(
  parameter int NTASK = 32,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [2:0]       sel,
  input  logic             rd,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NTASK-1:0] ovr_req,
  input  logic             intack,
  output logic             irq,
  output logic [NTASK-1:0] ack_vec,
  input  logic             id_en,
  input  logic             tf_en,
  input  logic             tf_in,
  input  logic             rdl_en,
  input  logic [DW-1:0]    rdl_data,
  output logic [DW-1:0]    wreg,
  output logic [4:0]       cmd_task,
  output logic [3:0]       cmd_code,
  output logic [1:0]       cmd_pace,
  output logic             cmd_valid,
  output logic             cmd_pend,
  input  logic             cmd_pend_clr
);
  localparam int IDW = 5;
  localparam logic [2:0] SEL_RDAT = 3'd0;
  localparam logic [2:0] SEL_WDAT = 3'd1;
  localparam logic [2:0] SEL_CMD  = 3'd2;
  localparam logic [2:0] SEL_STAT = 3'd3;

  logic [DW-1:0]  rdreg_q, wreg_q, cmd_q, status;
  logic [IDW-1:0] id_q, enc;
  logic           tf_q, irq_q, valid_q, pend_q;
  logic           cmd_wr, any_req;

  assign cmd_wr  = wr && (sel == SEL_CMD);
  assign any_req = |ovr_req;

  always_comb begin
    enc = '0;
    for (int i = NTASK - 1; i >= 0; i--)
      if (ovr_req[i]) enc = IDW'(i);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rdreg_q <= '0;
      wreg_q  <= '0;
      cmd_q   <= '0;
      id_q    <= '0;
      tf_q    <= 1'b0;
      irq_q   <= 1'b0;
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (rdl_en) rdreg_q <= rdl_data;
      if (wr && sel == SEL_WDAT) wreg_q <= wdata;
      if (cmd_wr) cmd_q <= wdata;
      valid_q <= cmd_wr;
      if (cmd_wr) pend_q <= 1'b1;
      else if (cmd_pend_clr) pend_q <= 1'b0;
      if (id_en) id_q <= enc;
      if (tf_en) tf_q <= tf_in;
      irq_q <= intack ? 1'b0 : (irq_q | any_req);
    end
  end

  always_comb begin
    status       = '0;
    status[4:0]  = id_q;
    status[5]    = tf_q;
  end

  assign rdata     = !rd ? '0 :
                     (sel == SEL_RDAT) ? rdreg_q :
                     (sel == SEL_STAT) ? status : '0;
  assign irq       = irq_q;
  assign ack_vec   = (intack && irq_q) ? (NTASK'(1) << id_q) : '0;
  assign wreg      = wreg_q;
  assign cmd_task  = cmd_q[4:0];
  assign cmd_code  = cmd_q[8:5];
  assign cmd_pace  = cmd_q[10:9];
  assign cmd_valid = valid_q;
  assign cmd_pend  = pend_q;

  AST_CMD_PEND:   assert property (@(posedge clk) disable iff (clr) cmd_valid |-> cmd_pend);              // R4
  AST_PEND_HOLD:  assert property (@(posedge clk) disable iff (clr) (cmd_pend && !cmd_pend_clr) |=> cmd_pend); // R4
  AST_IRQ_SET:    assert property (@(posedge clk) disable iff (clr) (any_req && !intack) |=> irq);      // R6
  AST_IRQ_HOLD:   assert property (@(posedge clk) disable iff (clr) (irq && !intack) |=> irq);          // R7
  AST_ACK_DROP:   assert property (@(posedge clk) disable iff (clr) intack |=> !irq);                   // R7
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (clr) $onehot0(ack_vec));                 // R7
  AST_ID_HOLD:    assert property (@(posedge clk) disable iff (clr) !id_en |=> $stable(status[4:0]));   // R8
  AST_STAT_HI:    assert property (@(posedge clk) disable iff (clr) (rd && sel == SEL_STAT) |-> rdata[DW-1:6] == '0); // R5
  AST_CLR_IRQ:    assert property (@(posedge clk) clr |=> !irq && !cmd_valid && !cmd_pend);             // R9
endmodule

// File: tb/tmon_host_regs_bench.sv
`timescale 1ns/1ps
module tmon_host_regs_bench;
  localparam int NT = 32;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic clr, rd, wr, intack, id_en, tf_en, tf_in, rdl_en, pclr;
  logic [2:0] sel;
  logic [DW-1:0] wdata, rdl_data, rdata, wreg;
  logic [NT-1:0] ovr_req, ack_vec;
  logic irq, cmd_valid, cmd_pend;
  logic [4:0] cmd_task;
  logic [3:0] cmd_code;
  logic [1:0] cmd_pace;

  tmon_host_regs #(.NTASK(NT), .DW(DW)) u_tmon_host_regs (
    .clk(clk), .clr(clr), .sel(sel), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata),
    .ovr_req(ovr_req), .intack(intack), .irq(irq), .ack_vec(ack_vec),
    .id_en(id_en), .tf_en(tf_en), .tf_in(tf_in), .rdl_en(rdl_en), .rdl_data(rdl_data),
    .wreg(wreg), .cmd_task(cmd_task), .cmd_code(cmd_code), .cmd_pace(cmd_pace),
    .cmd_valid(cmd_valid), .cmd_pend(cmd_pend), .cmd_pend_clr(pclr));

  int checks = 0;
  int errors = 0;

  logic nx_clr, nx_rd, nx_wr, nx_intack, nx_id_en, nx_tf_en, nx_tf_in, nx_rdl_en, nx_pclr;
  logic [2:0] nx_sel;
  logic [DW-1:0] nx_wdata, nx_rdl_data;
  logic [NT-1:0] nx_new;

  logic [DW-1:0] m_rdreg, m_wreg, m_cmd;
  logic [4:0] m_id;
  logic m_tf, m_irq, m_valid, m_pend;
  logic [NT-1:0] m_req;

  function automatic logic [4:0] penc(input logic [NT-1:0] r);
    penc = '0;
    for (int i = NT - 1; i >= 0; i--) if (r[i]) penc = 5'(i);
  endfunction

  function automatic logic [DW-1:0] exp_rdata();
    if (!rd) return '0;
    if (sel == 3'd0) return m_rdreg;
    if (sel == 3'd3) return {10'd0, m_tf, m_id};
    return '0;
  endfunction

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", what, got, exp, $time);
    end
  endtask

  task automatic idle_nx();
    nx_clr = 0; nx_rd = 0; nx_wr = 0; nx_intack = 0; nx_id_en = 0; nx_tf_en = 0;
    nx_tf_in = 0; nx_rdl_en = 0; nx_pclr = 0; nx_sel = 0; nx_wdata = 0;
    nx_rdl_data = 0; nx_new = 0;
  endtask

  task automatic cycle();
    logic [NT-1:0] ack;
    logic cw;
    @(negedge clk);
    chk("R2 write-data register", 32'(wreg), 32'(m_wreg));
    chk("R3 task field", 32'(cmd_task), 32'(m_cmd[4:0]));
    chk("R3 code field", 32'(cmd_code), 32'(m_cmd[8:5]));
    chk("R3 pace field", 32'(cmd_pace), 32'(m_cmd[10:9]));
    chk("R4 command pulse", 32'(cmd_valid), 32'(m_valid));
    chk("R4 pending flag", 32'(cmd_pend), 32'(m_pend));
    chk("R6 R7 interrupt line", 32'(irq), 32'(m_irq));
    clr = nx_clr; rd = nx_rd; wr = nx_wr; intack = nx_intack; id_en = nx_id_en;
    tf_en = nx_tf_en; tf_in = nx_tf_in; rdl_en = nx_rdl_en; pclr = nx_pclr;
    sel = nx_sel; wdata = nx_wdata; rdl_data = nx_rdl_data; ovr_req = m_req;
    #1;
    chk("R1 R5 R10 read data", 32'(rdata), 32'(exp_rdata()));
    ack = (intack && m_irq) ? (NT'(1) << m_id) : '0;
    chk("R7 acknowledge vector", 32'(ack_vec), 32'(ack));
    if (clr) begin
      m_rdreg = 0; m_wreg = 0; m_cmd = 0; m_id = 0; m_tf = 0;
      m_irq = 0; m_valid = 0; m_pend = 0; m_req = 0;
    end else begin
      if (rdl_en) m_rdreg = rdl_data;
      if (wr && sel == 3'd1) m_wreg = wdata;
      cw = wr && sel == 3'd2;
      if (cw) m_cmd = wdata;
      m_valid = cw;
      m_pend = cw ? 1'b1 : (pclr ? 1'b0 : m_pend);
      m_irq = intack ? 1'b0 : (m_irq | (m_req != 0));
      if (id_en) m_id = penc(m_req);
      if (tf_en) m_tf = tf_in;
      m_req = (m_req & ~ack) | nx_new;
    end
  endtask

  task automatic check_reset();
    @(posedge clk); #1;
    chk("R9 irq after clear", 32'(irq), 0);
    chk("R9 write-data after clear", 32'(wreg), 0);
    chk("R9 command after clear", 32'({cmd_pace, cmd_code, cmd_task}), 0);
    chk("R9 pulse and pending after clear", 32'({cmd_valid, cmd_pend}), 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clr = 1; rd = 0; wr = 0; intack = 0; id_en = 0; tf_en = 0; tf_in = 0; rdl_en = 0;
    pclr = 0; sel = 0; wdata = 0; rdl_data = 0; ovr_req = 0;
    m_rdreg = 0; m_wreg = 0; m_cmd = 0; m_id = 0; m_tf = 0;
    m_irq = 0; m_valid = 0; m_pend = 0; m_req = 0;
    idle_nx(); nx_clr = 1;
    cycle();
    check_reset();
    idle_nx();

    // R3 R4: command write with distinct fields, pulse then pending
    nx_wr = 1; nx_sel = 3'd2; nx_wdata = 16'hF000 | (2'b10 << 9) | (4'hB << 5) | 5'd19;
    cycle(); idle_nx();
    cycle();
    chk("R4 pulse after command write", 32'(cmd_valid), 1);
    chk("R3 code 0xB", 32'(cmd_code), 32'hB);
    nx_wr = 1; nx_sel = 3'd2; nx_wdata = 16'h0011; nx_pclr = 1;
    cycle(); idle_nx();
    cycle();
    chk("R4 write beats pending clear", 32'(cmd_pend), 1);

    // R10: writes to read-only selects are ignored
    nx_wr = 1; nx_sel = 3'd0; nx_wdata = 16'hBEEF; cycle(); idle_nx();
    nx_wr = 1; nx_sel = 3'd3; nx_wdata = 16'hFFFF; cycle(); idle_nx();
    nx_rd = 1; nx_sel = 3'd3; cycle(); idle_nx();
    chk("R10 status untouched by write", 32'(rdata), 0);

    // R8: two simultaneous requests, lowest index wins
    nx_new = (NT'(1) << 20) | (NT'(1) << 5); cycle(); idle_nx();
    nx_id_en = 1; cycle(); idle_nx();
    cycle();
    chk("R6 irq raised", 32'(irq), 1);
    nx_new = NT'(1) << 2; cycle(); idle_nx();
    cycle();
    nx_rd = 1; nx_sel = 3'd3; cycle(); idle_nx();
    chk("R8 captured ID held at 5", 32'(rdata[4:0]), 5);
    // R7: acknowledge drops irq for one cycle, then it re-raises
    nx_intack = 1; cycle(); idle_nx();
    cycle();
    chk("R7 irq low after acknowledge", 32'(irq), 0);
    cycle();
    chk("R6 irq re-raised by pending requests", 32'(irq), 1);
    nx_id_en = 1; cycle(); idle_nx();
    nx_rd = 1; nx_sel = 3'd3; cycle(); idle_nx();
    chk("R8 next ID is 2", 32'(rdata[4:0]), 2);

    // R9 mid-run clear, then task 31 alone
    nx_clr = 1; cycle(); check_reset(); idle_nx();
    nx_new = NT'(1) << 31; cycle(); idle_nx();
    nx_id_en = 1; nx_tf_en = 1; nx_tf_in = 1; cycle(); idle_nx();
    nx_rd = 1; nx_sel = 3'd3; cycle(); idle_nx();
    chk("R5 status ID 31 and too-fast flag", 32'(rdata), 32'h003F);
    nx_rdl_en = 1; nx_rdl_data = 16'h5A3C; cycle(); idle_nx();
    nx_rd = 1; nx_sel = 3'd0; cycle(); idle_nx();
    chk("R1 read-data register", 32'(rdata), 32'h5A3C);

    for (int n = 0; n < 4000; n++) begin
      nx_clr = ($urandom % 600) == 0;
      nx_sel = 3'($urandom);
      nx_rd = 1'($urandom);
      nx_wr = 1'($urandom);
      nx_wdata = 16'($urandom);
      nx_new = (($urandom % 6) == 0) ? (NT'(1) << ($urandom % NT)) : '0;
      nx_intack = m_irq ? (($urandom % 4) == 0) : (($urandom % 16) == 0);
      nx_id_en = ($urandom % 3) == 0;
      nx_tf_en = ($urandom % 4) == 0;
      nx_tf_in = 1'($urandom);
      nx_rdl_en = ($urandom % 4) == 0;
      nx_rdl_data = 16'($urandom);
      nx_pclr = ($urandom % 4) == 0;
      cycle();
    end
    idle_nx();
    cycle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule